// File: doc/BRIEF.md
# Deferred-Exception Poison Tag Tracker

This block keeps one poison bit beside each general register of a core and uses those bits to defer faults. A speculative load that takes an exception does not trap. It marks its destination as poisoned. Ordinary compute operations carry the poison from their sources into their results. The fault surfaces only when a non-speculative operation consumes a poisoned value, or when an explicit check operation asks for a branch to recovery code. The block tracks only the tags. Data values and the execution units belong to neighbouring logic.

Each cycle the pipeline presents one operation descriptor: a valid bit, a kind, a destination index, two source indices and a fault flag for speculative loads. A separate restore port lets the state save and restore sequence write any tag directly. A read port returns any tag, and it already reflects a write landing in the same cycle, so a save sequence can read state without stalling. Fault and check-branch indications are registered. Each appears in the cycle after the operation that caused it.

Top module: `spec_tag_unit`

## Requirements
- R1: A synchronous active-high reset clears every tag and drives `faultOut` and `checkBranch` low.
- R2: A speculative load (kind 2) writes its destination tag as the OR of its first source's tag (the address register) and `opFault`. With a clean address and no fault, the destination tag is cleared.
- R3: A propagating operation (kind 1) writes its destination tag as the OR of the tags of both sources.
- R4: A non-speculative load (kind 3) whose first source is tagged, or a store (kind 4) with either source tagged, drives `faultOut` high for exactly the next cycle. Such an operation leaves its destination tag unchanged. A load with a clean source clears its destination tag.
- R5: A check operation (kind 5) drives `checkBranch` high in the next cycle exactly when its first source is tagged. It writes no tag and raises no fault.
- R6: When `rsEn` is high, the restore port writes `rsTag` into register `rsIdx` at the clock edge. If the operation writes the same register in the same cycle, the operation's value wins. Operation sources read the tag as it stood before the edge.
- R7: The tag of register 0 always reads 0, and writes to it have no effect.
- R8: `rdTag` returns the tag of `rdIdx`. When a write to that register lands at the coming edge, `rdTag` already returns the value being written.
- R9: `opFault` has no effect on any kind other than the speculative load.
- R10: An operation with `opValid` low, or with an undefined kind (0, 6, 7), changes no tag and raises neither output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | Operation descriptor valid this cycle |
| opKind | input | 3 | Operation kind: 1 propagate, 2 speculative load, 3 load, 4 store, 5 check |
| opDst | input | 7 | Destination register index |
| opSrcA | input | 7 | First source index (address for loads, tested register for check) |
| opSrcB | input | 7 | Second source index |
| opFault | input | 1 | The speculative load hit an exception |
| rsEn | input | 1 | Restore-port write enable |
| rsIdx | input | 7 | Restore-port register index |
| rsTag | input | 1 | Restore-port tag value |
| rdIdx | input | 7 | Read-port register index |
| rdTag | output | 1 | Tag of `rdIdx`, with same-cycle writes bypassed |
| faultOut | output | 1 | Immediate fault from a poisoned non-speculative use |
| checkBranch | output | 1 | Check found a poisoned register; branch to recovery |

## Verification
A wrong tag stays silent at first. It becomes visible only when a later load, store or check reads that register, and then it shows one cycle after that consumer as a missing or spurious `faultOut` or `checkBranch`. The bench therefore follows every operation with a direct read of the affected tag through `rdTag`, so a corrupted bit is caught in the cycle right after the write. Same-cycle bypass and write-port priority are also sampled before the edge, so an error there appears on `rdTag` in that same cycle.

// File: rtl/spec_tag_pkg.sv
package spec_tag_pkg;

  localparam int KIND_W = 3;

  localparam logic [KIND_W-1:0] K_NOP    = 3'd0;
  localparam logic [KIND_W-1:0] K_PROP   = 3'd1;
  localparam logic [KIND_W-1:0] K_SPECLD = 3'd2;
  localparam logic [KIND_W-1:0] K_LOAD   = 3'd3;
  localparam logic [KIND_W-1:0] K_STORE  = 3'd4;
  localparam logic [KIND_W-1:0] K_CHECK  = 3'd5;

  // strobes from control to the tag store
  typedef struct packed {
    logic wrEn;        // write the operation's destination tag
    logic wrTag;       // value to write
    logic raiseFault;  // poisoned non-speculative use
    logic takeCheck;   // check found poison
  } tagStrobe_t;

endpackage

// File: rtl/spec_tag_ctrl.sv
module spec_tag_ctrl
  import spec_tag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [KIND_W-1:0] opKind,
  input  logic              opFault,
  input  logic              tagA,
  input  logic              tagB,
  output tagStrobe_t        stb,
  output logic              faultOut,
  output logic              checkBranch
);

  always_comb begin
    stb = '0;
    if (opValid) begin
      unique case (opKind)
        K_PROP: begin
          stb.wrEn  = 1'b1;
          stb.wrTag = tagA | tagB;
        end
        K_SPECLD: begin
          stb.wrEn  = 1'b1;
          stb.wrTag = tagA | opFault;
        end
        K_LOAD: begin
          if (tagA) begin
            stb.raiseFault = 1'b1;
          end else begin
            stb.wrEn  = 1'b1;
            stb.wrTag = 1'b0;
          end
        end
        K_STORE: stb.raiseFault = tagA | tagB;
        K_CHECK: stb.takeCheck  = tagA;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      faultOut    <= 1'b0;
      checkBranch <= 1'b0;
    end else begin
      faultOut    <= stb.raiseFault;
      checkBranch <= stb.takeCheck;
    end
  end

  // a fault only follows a load or store
  p_fault_from_consumer_r4: assert property (@(posedge clk) disable iff (rst)
    faultOut |-> ($past(opValid) && ($past(opKind) == K_LOAD || $past(opKind) == K_STORE)));

  // a branch only follows a check
  p_branch_from_check_r5: assert property (@(posedge clk) disable iff (rst)
    checkBranch |-> ($past(opValid) && $past(opKind) == K_CHECK));

  // a check never raises a fault
  p_check_no_fault_r5: assert property (@(posedge clk) disable iff (rst)
    !(faultOut && checkBranch));

endmodule

// File: rtl/spec_tag_store.sv
module spec_tag_store
  import spec_tag_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter bit HARD_ZERO = 1'b1,
  localparam int IDX_W    = $clog2(NUM_REGS)
)(
  input  logic             clk,
  input  logic             rst,
  input  tagStrobe_t       stb,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] srcAIdx,
  input  logic [IDX_W-1:0] srcBIdx,
  input  logic             rsEn,
  input  logic [IDX_W-1:0] rsIdx,
  input  logic             rsTag,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             tagA,
  output logic             tagB,
  output logic             rdTag
);

  logic [NUM_REGS-1:0] tagQ;
  logic [NUM_REGS-1:0] tagMerged;
  logic [NUM_REGS-1:0] tagD;

  // restore first, operation second: the operation wins
  always_comb begin
    tagMerged = tagQ;
    if (rsEn)     tagMerged[rsIdx]  = rsTag;
    if (stb.wrEn) tagMerged[dstIdx] = stb.wrTag;
  end

  generate
    if (HARD_ZERO) begin : g_zero
      always_comb begin
        tagD    = tagMerged;
        tagD[0] = 1'b0;
      end
    end else begin : g_plain
      assign tagD = tagMerged;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tagQ <= '0;
    else     tagQ <= tagD;
  end

  assign tagA  = tagQ[srcAIdx];
  assign tagB  = tagQ[srcBIdx];
  assign rdTag = tagD[rdIdx];   // bypass of the incoming write

  // a faulting consumer leaves its destination tag untouched
  p_fault_keeps_dest_r4: assert property (@(posedge clk) disable iff (rst)
    (stb.raiseFault && !(rsEn && rsIdx == dstIdx))
      |=> tagQ[$past(dstIdx)] == $past(tagQ[dstIdx]));

endmodule

// File: rtl/spec_tag_unit.sv
module spec_tag_unit
  import spec_tag_pkg::*;
#(
  parameter int NUM_REGS = 128,
  localparam int IDX_W   = $clog2(NUM_REGS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [KIND_W-1:0] opKind,
  input  logic [IDX_W-1:0]  opDst,
  input  logic [IDX_W-1:0]  opSrcA,
  input  logic [IDX_W-1:0]  opSrcB,
  input  logic              opFault,
  input  logic              rsEn,
  input  logic [IDX_W-1:0]  rsIdx,
  input  logic              rsTag,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdTag,
  output logic              faultOut,
  output logic              checkBranch
);

  tagStrobe_t stb;
  logic       tagA;
  logic       tagB;

  spec_tag_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opValid(opValid), .opKind(opKind),
    .opFault(opFault), .tagA(tagA), .tagB(tagB), .stb(stb),
    .faultOut(faultOut), .checkBranch(checkBranch)
  );

  spec_tag_store #(.NUM_REGS(NUM_REGS), .HARD_ZERO(1'b1)) u_store (
    .clk(clk), .rst(rst), .stb(stb), .dstIdx(opDst),
    .srcAIdx(opSrcA), .srcBIdx(opSrcB), .rsEn(rsEn), .rsIdx(rsIdx),
    .rsTag(rsTag), .rdIdx(rdIdx), .tagA(tagA), .tagB(tagB), .rdTag(rdTag)
  );

endmodule

// File: tb/sim_spec_tag_unit.sv
module sim_spec_tag_unit;

  localparam int PERIOD = 10;
  localparam int NV     = 16;

  logic       clk = 1'b0;
  logic       rst;
  logic       opValid, opFault, rsEn, rsTag;
  logic [2:0] opKind;
  logic [6:0] opDst, opSrcA, opSrcB, rsIdx, rdIdx;
  logic       rdTag, faultOut, checkBranch;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  spec_tag_unit u0 (
    .clk(clk), .rst(rst), .opValid(opValid), .opKind(opKind), .opDst(opDst),
    .opSrcA(opSrcA), .opSrcB(opSrcB), .opFault(opFault), .rsEn(rsEn),
    .rsIdx(rsIdx), .rsTag(rsTag), .rdIdx(rdIdx), .rdTag(rdTag),
    .faultOut(faultOut), .checkBranch(checkBranch)
  );

  function automatic logic [35:0] mk(logic v, logic [2:0] k, logic [6:0] d,
      logic [6:0] a, logic [6:0] b, logic f, logic ef, logic ec,
      logic [6:0] ci, logic et);
    return {v, k, d, a, b, f, ef, ec, ci, et};
  endfunction

  // valid kind dst srcA srcB fault | expFault expBranch readIdx expTag
  localparam logic [35:0] VECS [0:NV-1] = '{
    mk(1, 2,  5, 1, 0, 1, 0, 0,  5, 1),  // R2 faulting spec load sets tag
    mk(1, 2,  6, 2, 0, 0, 0, 0,  6, 0),  // R2 clean spec load
    mk(1, 1,  7, 5, 6, 0, 0, 0,  7, 1),  // R3 first source poisoned
    mk(1, 1,  8, 6, 9, 1, 0, 0,  8, 0),  // R9 fault flag ignored on propagate
    mk(1, 1,  9, 3, 7, 0, 0, 0,  9, 1),  // R3 second source poisoned
    mk(1, 5,  0, 9, 0, 0, 0, 1,  9, 1),  // R5 check hits poison
    mk(1, 5,  0, 8, 0, 0, 0, 0,  8, 0),  // R5 check clean
    mk(1, 2, 10, 0, 0, 1, 0, 0, 10, 1),  // R2 set up r10
    mk(1, 3, 10, 7, 0, 0, 1, 0, 10, 1),  // R4 poisoned load faults, dest kept
    mk(1, 3, 10, 6, 0, 0, 0, 0, 10, 0),  // R4 clean load clears dest
    mk(1, 4,  0, 6, 5, 0, 1, 0,  5, 1),  // R4 store poisoned data source
    mk(1, 4,  0, 6, 8, 0, 0, 0,  8, 0),  // R4 clean store
    mk(1, 2,  0, 0, 0, 1, 0, 0,  0, 0),  // R7 write to r0 dropped
    mk(0, 1, 11, 5, 5, 0, 0, 0, 11, 0),  // R10 invalid op
    mk(1, 2, 12, 5, 0, 0, 0, 0, 12, 1),  // R2 poisoned address
    mk(1, 6, 13, 5, 5, 1, 0, 0, 13, 0)   // R10 undefined kind
  };
  localparam string VREQ [0:NV-1] = '{"R2","R2","R3","R9","R3","R5","R5","R2",
                                      "R4","R4","R4","R4","R7","R10","R2","R10"};

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle();
    opValid = 0; opKind = 0; opDst = 0; opSrcA = 0; opSrcB = 0; opFault = 0;
    rsEn = 0; rsIdx = 0; rsTag = 0;
  endtask

  initial begin
    #(PERIOD*100000);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    idle(); rdIdx = 5; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    check("R1 fault", faultOut, 0);
    check("R1 branch", checkBranch, 0);
    check("R1 tag", rdTag, 0);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VECS[i];
      @(negedge clk);
      opValid = v[35]; opKind = v[34:32]; opDst = v[31:25];
      opSrcA = v[24:18]; opSrcB = v[17:11]; opFault = v[10];
      @(negedge clk);
      idle(); rdIdx = v[7:1];
      #1;
      check({VREQ[i], " fault"},  faultOut,    v[9]);
      check({VREQ[i], " branch"}, checkBranch, v[8]);
      check({VREQ[i], " tag"},    rdTag,       v[0]);
    end

    // R6 restore write
    @(negedge clk);
    rsEn = 1; rsIdx = 20; rsTag = 1;
    @(negedge clk);
    idle(); rdIdx = 20; #1;
    check("R6 restore", rdTag, 1);

    // R8 bypass from restore port, sampled before the edge
    @(negedge clk);
    rsEn = 1; rsIdx = 21; rsTag = 1; rdIdx = 21; #1;
    check("R8 restore bypass", rdTag, 1);
    @(negedge clk);
    idle(); #1;
    check("R8 restore held", rdTag, 1);

    // R8 bypass from operation write
    @(negedge clk);
    opValid = 1; opKind = 2; opDst = 22; opSrcA = 0; opFault = 1; rdIdx = 22; #1;
    check("R8 op bypass", rdTag, 1);
    @(negedge clk);
    idle();

    // R6 same-register conflict: operation wins
    @(negedge clk);
    opValid = 1; opKind = 2; opDst = 23; opSrcA = 0; opFault = 0;
    rsEn = 1; rsIdx = 23; rsTag = 1; rdIdx = 23; #1;
    check("R6 conflict bypass", rdTag, 0);
    @(negedge clk);
    idle(); #1;
    check("R6 conflict", rdTag, 0);

    // R7 restore into r0
    @(negedge clk);
    rsEn = 1; rsIdx = 0; rsTag = 1;
    @(negedge clk);
    idle(); rdIdx = 0; #1;
    check("R7 restore r0", rdTag, 0);

    // R6 cleared tag no longer triggers a check
    @(negedge clk);
    rsEn = 1; rsIdx = 5; rsTag = 0;
    @(negedge clk);
    idle(); opValid = 1; opKind = 5; opSrcA = 5;
    @(negedge clk);
    idle(); #1;
    check("R6 restored clean", checkBranch, 0);

    // R1 reset mid-run clears tags
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0; rdIdx = 7; #1;
    check("R1 reset tag", rdTag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule